// File: doc/BRIEF.md
# Prioritized Vector Interrupt Controller

This block tracks 256 interrupt vectors on behalf of one processor core. Three bitmaps hold the vector state: pending, in service, and level-triggered. Fixed-mode requests arrive on a single request port. The block works out the processor priority from a task-priority value and the highest vector in service. It then offers the core the highest pending vector whose priority class beats that priority.

The core takes the offered vector with a one-cycle acknowledge pulse, which moves the vector from pending to in service. When the handler finishes, the core pulses end-of-interrupt. This retires the highest in-service vector and reports that vector to the request sources together with its trigger mode. Level-triggered sources can then re-assert.

Within one clock edge, events are applied in a fixed order: end-of-interrupt first, then acknowledge, then the new request. The task-priority write lands in the same edge, and all outputs are computed from the resulting state.

Top module: `vic_core`

## Requirements
- R1: After a synchronous reset, the following are cleared: all three bitmaps, the task priority, `proc_prio`, `irq_valid` and `eoi_valid`.
- R2: A request with both `hw_en` and `sw_en` high marks its vector pending. If the vector is deliverable, it appears on `irq_vector` with `irq_valid` high one cycle after the request edge.
- R3: `proc_prio` equals the task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector. Otherwise it equals that vector with its low nibble cleared. An empty in-service set counts as vector 0.
- R4: `irq_valid` is high exactly when the highest pending vector, with its low nibble cleared, is strictly greater than `proc_prio`. `irq_vector` then carries that vector. Lower pending vectors are never offered ahead of it.
- R5: `ack` while `irq_valid` is high moves `irq_vector` from pending to in service, and `proc_prio` follows in the next cycle. `ack` while `irq_valid` is low has no effect.
- R6: `eoi` retires the highest in-service vector and clears that vector's level bit. In the next cycle it raises `eoi_valid` for one cycle, with `eoi_vector` set to the retired vector and `eoi_level` set to the level bit it held (1 for level, 0 for edge).
- R7: `eoi` with nothing in service leaves all state unchanged and does not raise `eoi_valid`.
- R8: A request for a vector that is already pending is discarded, together with its trigger mode. Otherwise the request's `req_level` is stored as that vector's level bit.
- R9: A request is discarded when `hw_en` or `sw_en` is low.
- R10: A `tpr_wr` stores all 8 bits of `tpr_data`, and `proc_prio` reflects the new value in the next cycle.
- R11: When `ack` and a request for the acknowledged vector arrive in the same cycle, the vector ends up both in service and pending again. Its level bit takes the new request's trigger mode.
- R12: When `eoi` and `ack` arrive in the same cycle, `eoi` retires the highest vector that was in service before the acknowledged vector joins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Hardware enable for accepting requests |
| sw_en | input | 1 | Software enable for accepting requests |
| req_valid | input | 1 | Fixed-mode request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_data | input | 8 | Task-priority value |
| ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_valid | output | 1 | A deliverable vector is offered |
| irq_vector | output | 8 | Offered vector |
| proc_prio | output | 8 | Current processor priority |
| eoi_valid | output | 1 | One-cycle end-of-interrupt report |
| eoi_vector | output | 8 | Vector retired by the end-of-interrupt |
| eoi_level | output | 1 | Trigger mode of the retired vector |

## Verification
Every output is registered from the state that an edge produces. The effect of any request, acknowledge, end-of-interrupt or task-priority write is therefore due exactly one cycle after the edge that samples it. The bench drives stimulus on the falling edge and advances its behavioural model on the rising edge. It compares `irq_valid`, `irq_vector`, `proc_prio` and the end-of-interrupt report at the following falling edge, so each result is read in the cycle it is due. The directed sequences add fixed expected values for the same-cycle orderings and for the dropped-request cases. A randomized phase then runs the model comparison over long mixed traffic.

// File: rtl/vic_pkg.sv
package vic_pkg;

    parameter int VEC_W   = 8;
    parameter int NUM_VEC = 256;
    parameter int WORD_W  = 32;
    parameter int CLS_W   = 4;

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
    } hit_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
        logic level;
    } eoi_msg_t;

    function automatic logic [CLS_W-1:0] class_of(input vec_t v);
        return v[VEC_W-1 -: CLS_W];
    endfunction

    function automatic vec_t class_floor(input vec_t v);
        return {v[VEC_W-1 -: CLS_W], {(VEC_W-CLS_W){1'b0}}};
    endfunction

endpackage

// File: rtl/vic_bitscan.sv
module vic_bitscan
    import vic_pkg::*;
#(
    parameter int N_VEC  = NUM_VEC,
    parameter int WORD_B = WORD_W
) (
    input  logic [N_VEC-1:0] bits,
    output hit_t             top
);
    localparam int NW = N_VEC / WORD_B;
    localparam int BW = $clog2(WORD_B);

    logic [NW-1:0] w_any;
    logic [BW-1:0] w_idx [NW];

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [WORD_B-1:0] word;
        assign word     = bits[w*WORD_B +: WORD_B];
        assign w_any[w] = |word;
        always_comb begin
            w_idx[w] = '0;
            for (int b = 0; b < WORD_B; b++) begin
                if (word[b]) w_idx[w] = BW'(b);
            end
        end
    end

    // Scan words from low to high so that the topmost non-empty word wins.
    always_comb begin
        top = '0;
        for (int w = 0; w < NW; w++) begin
            if (w_any[w]) begin
                top.valid = 1'b1;
                top.vec   = VEC_W'(w * WORD_B) | VEC_W'(w_idx[w]);
            end
        end
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
(
    input  vec_t tpr,
    input  hit_t isr_top,
    input  hit_t irr_top,
    output vec_t ppr,
    output hit_t offer
);
    vec_t isr_v;

    always_comb begin
        isr_v = isr_top.valid ? isr_top.vec : '0;
        if (class_of(tpr) >= class_of(isr_v)) ppr = tpr;
        else                                  ppr = class_floor(isr_v);
        offer.valid = irr_top.valid && (class_floor(irr_top.vec) > ppr);
        offer.vec   = irr_top.vec;
    end
endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_en,
    input  logic       sw_en,
    input  logic       req_valid,
    input  logic [7:0] req_vector,
    input  logic       req_level,
    input  logic       tpr_wr,
    input  logic [7:0] tpr_data,
    input  logic       ack,
    input  logic       eoi,
    output logic       irq_valid,
    output logic [7:0] irq_vector,
    output logic [7:0] proc_prio,
    output logic       eoi_valid,
    output logic [7:0] eoi_vector,
    output logic       eoi_level
);
    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
    vec_t     tpr_q, tpr_n, ppr_q, ppr_n;
    logic     irq_valid_q;
    vec_t     irq_vec_q;
    eoi_msg_t eoi_q, eoi_n;
    hit_t     isr_cur, isr_nxt, irr_nxt, offer_n;
    logic     accept_en, ack_take;

    vic_bitscan u_scan_isr_cur (.bits(isr_q), .top(isr_cur));
    vic_bitscan u_scan_isr_nxt (.bits(isr_n), .top(isr_nxt));
    vic_bitscan u_scan_irr_nxt (.bits(irr_n), .top(irr_nxt));

    vic_prio u_prio (
        .tpr    (tpr_n),
        .isr_top(isr_nxt),
        .irr_top(irr_nxt),
        .ppr    (ppr_n),
        .offer  (offer_n)
    );

    assign accept_en = hw_en && sw_en;
    assign ack_take  = ack && irq_valid_q;

    // Fixed order within one edge: retire, then take, then accept.
    always_comb begin
        irr_n = irr_q;
        isr_n = isr_q;
        tmr_n = tmr_q;
        tpr_n = tpr_wr ? tpr_data : tpr_q;
        eoi_n = '0;
        if (eoi && isr_cur.valid) begin
            isr_n[isr_cur.vec] = 1'b0;
            tmr_n[isr_cur.vec] = 1'b0;
            eoi_n.valid        = 1'b1;
            eoi_n.vec          = isr_cur.vec;
            eoi_n.level        = tmr_q[isr_cur.vec];
        end
        if (ack_take) begin
            isr_n[irq_vec_q] = 1'b1;
            irr_n[irq_vec_q] = 1'b0;
        end
        if (req_valid && accept_en && !irr_n[req_vector]) begin
            irr_n[req_vector] = 1'b1;
            tmr_n[req_vector] = req_level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q       <= '0;
            isr_q       <= '0;
            tmr_q       <= '0;
            tpr_q       <= '0;
            ppr_q       <= '0;
            irq_valid_q <= 1'b0;
            irq_vec_q   <= '0;
            eoi_q       <= '0;
        end else begin
            irr_q       <= irr_n;
            isr_q       <= isr_n;
            tmr_q       <= tmr_n;
            tpr_q       <= tpr_n;
            ppr_q       <= ppr_n;
            irq_valid_q <= offer_n.valid;
            irq_vec_q   <= offer_n.vec;
            eoi_q       <= eoi_n;
        end
    end

    assign irq_valid  = irq_valid_q;
    assign irq_vector = irq_vec_q;
    assign proc_prio  = ppr_q;
    assign eoi_valid  = eoi_q.valid;
    assign eoi_vector = eoi_q.vec;
    assign eoi_level  = eoi_q.level;

    // R3
    ppr_floor_chk: assert property (@(posedge clk) disable iff (rst)
        class_of(ppr_q) >= class_of(tpr_q));

    // R4
    offer_above_ppr_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid_q |-> (class_of(irq_vec_q) > class_of(ppr_q)));

    // R5
    ack_sets_isr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_valid_q) |=> isr_q[$past(irq_vec_q)]);

    // R6
    eoi_cause_chk: assert property (@(posedge clk) disable iff (rst)
        eoi_q.valid |-> $past(eoi));

    // R7
    eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi && !(|isr_q)) |=> !eoi_q.valid);

    // R9
    disabled_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(hw_en && sw_en) && !irr_q[req_vector] && !ack)
            |=> !irr_q[$past(req_vector)]);
endmodule

// File: tb/tb_vic_core.sv
module tb_vic_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hw_en = 1'b1, sw_en = 1'b1;
    logic       req_valid = 1'b0, req_level = 1'b0;
    logic [7:0] req_vector = '0;
    logic       tpr_wr = 1'b0;
    logic [7:0] tpr_data = '0;
    logic       ack = 1'b0, eoi = 1'b0;
    logic       irq_valid, eoi_valid, eoi_level;
    logic [7:0] irq_vector, proc_prio, eoi_vector;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural reference state
    logic [255:0] m_irr, m_isr, m_tmr;
    int m_tpr, m_ppr, m_irqv, m_irqvec, m_eoiv, m_eoivec, m_eoilvl;

    always #4 clk = ~clk;

    vic_core dut (
        .clk(clk), .rst(rst), .hw_en(hw_en), .sw_en(sw_en),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .tpr_wr(tpr_wr), .tpr_data(tpr_data), .ack(ack), .eoi(eoi),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .proc_prio(proc_prio),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level)
    );

    function automatic int top_of(input logic [255:0] b);
        for (int i = 255; i >= 0; i--) if (b[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_irr = '0; m_isr = '0; m_tmr = '0;
        m_tpr = 0; m_ppr = 0; m_irqv = 0; m_irqvec = 0;
        m_eoiv = 0; m_eoivec = 0; m_eoilvl = 0;
    endtask

    task automatic model_step();
        int hi, isrv, p;
        hi = top_of(m_isr);
        m_eoiv = 0; m_eoivec = 0; m_eoilvl = 0;
        if (eoi && hi >= 0) begin
            m_eoiv = 1; m_eoivec = hi; m_eoilvl = int'(m_tmr[hi]);
            m_isr[hi] = 1'b0; m_tmr[hi] = 1'b0;
        end
        if (ack && m_irqv != 0) begin
            m_isr[m_irqvec] = 1'b1;
            m_irr[m_irqvec] = 1'b0;
        end
        if (req_valid && hw_en && sw_en && !m_irr[req_vector]) begin
            m_irr[req_vector] = 1'b1;
            m_tmr[req_vector] = req_level;
        end
        if (tpr_wr) m_tpr = int'(tpr_data);
        isrv = top_of(m_isr);
        if (isrv < 0) isrv = 0;
        if ((m_tpr / 16) >= (isrv / 16)) m_ppr = m_tpr;
        else m_ppr = (isrv / 16) * 16;
        p = top_of(m_irr);
        m_irqv = (p >= 0 && ((p / 16) * 16) > m_ppr) ? 1 : 0;
        m_irqvec = (p >= 0) ? p : 0;
    endtask

    task automatic compare_all();
        chk("R4 irq_valid", int'(irq_valid), m_irqv);
        if (m_irqv != 0) chk("R4 irq_vector", int'(irq_vector), m_irqvec);
        chk("R3 proc_prio", int'(proc_prio), m_ppr);
        chk("R6 eoi_valid", int'(eoi_valid), m_eoiv);
        if (m_eoiv != 0) begin
            chk("R6 eoi_vector", int'(eoi_vector), m_eoivec);
            chk("R6 eoi_level", int'(eoi_level), m_eoilvl);
        end
    endtask

    // Drive at the falling edge, update model at the rising edge,
    // compare at the next falling edge.
    task automatic step(input bit rq, input int vec, input bit lvl,
                        input bit ak, input bit eo, input bit tw, input int td);
        req_valid = rq; req_vector = 8'(vec); req_level = lvl;
        ack = ak; eoi = eo; tpr_wr = tw; tpr_data = 8'(td);
        @(posedge clk);
        model_step();
        @(negedge clk);
        req_valid = 1'b0; ack = 1'b0; eoi = 1'b0; tpr_wr = 1'b0;
        compare_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq_valid", int'(irq_valid), 0);
        chk("R1 proc_prio", int'(proc_prio), 0);
        chk("R1 eoi_valid", int'(eoi_valid), 0);

        step(1, 'h41, 0, 0, 0, 0, 0);
        chk("R2 offer 0x41", int'(irq_vector), 'h41);
        step(1, 'h35, 0, 0, 0, 0, 0);
        chk("R4 highest kept", int'(irq_vector), 'h41);
        step(1, 'h92, 0, 0, 0, 0, 0);
        chk("R4 higher wins", int'(irq_vector), 'h92);
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R5 ppr after ack", int'(proc_prio), 'h90);
        chk("R5 no offer below", int'(irq_valid), 0);
        step(0, 0, 0, 0, 0, 1, 'hA3);
        chk("R10 tpr 0xA3", int'(proc_prio), 'hA3);
        step(0, 0, 0, 0, 0, 1, 'h05);
        chk("R3 isr class wins", int'(proc_prio), 'h90);
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R6 eoi vector", int'(eoi_vector), 'h92);
        chk("R6 eoi edge", int'(eoi_level), 0);
        chk("R3 ppr back to tpr", int'(proc_prio), 'h05);
        step(1, 'h41, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R8 duplicate level dropped", int'(eoi_level), 0);
        chk("R8 eoi vector 0x41", int'(eoi_vector), 'h41);
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R7 empty eoi silent", int'(eoi_valid), 0);
        chk("R7 offer unchanged", int'(irq_vector), 'h35);
        hw_en = 1'b0;
        step(1, 'hE0, 0, 0, 0, 0, 0);
        chk("R9 hw disabled drop", int'(irq_vector), 'h35);
        hw_en = 1'b1; sw_en = 1'b0;
        step(1, 'hE0, 0, 0, 0, 0, 0);
        chk("R9 sw disabled drop", int'(irq_vector), 'h35);
        sw_en = 1'b1;
        step(1, 'h35, 1, 1, 0, 0, 0);
        chk("R11 masked while in service", int'(irq_valid), 0);
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R11 new level mode", int'(eoi_level), 1);
        chk("R11 still pending", int'(irq_vector), 'h35);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R6 level bit cleared", int'(eoi_level), 0);
        step(1, 'h60, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(1, 'hC0, 0, 0, 0, 0, 0);
        chk("R4 class above ppr", int'(irq_vector), 'hC0);
        step(0, 0, 0, 1, 1, 0, 0);
        chk("R12 eoi retires old", int'(eoi_vector), 'h60);
        chk("R12 ppr from taken", int'(proc_prio), 'hC0);
        step(0, 0, 0, 0, 1, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            hw_en = ($urandom % 20) != 0;
            sw_en = ($urandom % 20) != 0;
            step(($urandom % 3) != 0, int'($urandom % 256), bit'($urandom % 2),
                 bit'($urandom % 2), ($urandom % 4) == 0,
                 ($urandom % 16) == 0, int'($urandom % 256));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule